// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Flags

This block is the arithmetic and logic unit for a small 8-bit accumulator machine. When a strobe is present it takes an operation code, the accumulator, a second operand, the auxiliary B register and the incoming carry, auxiliary-carry and overflow flags. In the next clock cycle it presents the new accumulator value, a second result byte for B, and the updated carry, auxiliary-carry, overflow and parity flags. Those outputs hold until the next strobe.

The surrounding core does the instruction decoding and owns the register file. It passes operands in and writes the registered results back. Flags that an operation does not define come back equal to their inputs, so the core can write the whole flag set back after every operation.

Top module: `acc_alu8`

## Requirements
- R1: Outputs are registered. When `op_valid` is sampled high at a rising edge, all results and flags appear right after that edge and `res_valid` goes high for one cycle. Without `op_valid` the results hold their values. A synchronous active-low reset clears every output to 0.
- R2: ADD (code 0) and ADDC (code 1, which also adds `cy_in`) produce the 8-bit sum. CY is the carry out of bit 7 and AC is the carry out of bit 3. OV is set when both operands have the same sign and the result's sign differs from it.
- R3: SUBB (code 2) produces A minus the operand minus `cy_in`. CY is the borrow out of bit 7 and AC is the borrow out of bit 3. OV is set when the operand signs differ and the result's sign differs from A's sign.
- R4: INC (3) and DEC (4) wrap modulo 256. AND (5), OR (6) and XOR (7) combine A with the operand. Codes 17 to 31 pass A through unchanged. For all of these, CY, AC and OV equal their inputs.
- R5: RL (8) and RR (10) rotate A by one bit and leave CY unchanged. RLC (9) and RRC (11) rotate through carry: the old CY fills the vacated bit and the bit shifted out becomes CY.
- R6: SWAP (12) exchanges the two nibbles of A.
- R7: Decimal adjust, DA (13), works in two steps. It adds 6 when the low nibble exceeds 9 or AC is set. It then adds 0x60 when the high nibble exceeds 9 or the carry is set. CY is set if either step carries out or if CY was already set, so the result marks a BCD value above 99. AC and OV pass through.
- R8: Compare, CMP (14), leaves A unchanged. It sets CY when A is unsigned-less than the operand and clears CY otherwise.
- R9: MUL (15) forms A times B. The low byte goes to the result and the high byte to `res_b`. CY is cleared and OV is set exactly when the product exceeds 255.
- R10: DIV (16) with a nonzero B returns the quotient of A by B as the result and the remainder in `res_b`. CY and OV are cleared.
- R11: DIV with B equal to zero returns A and B unchanged, clears CY and sets OV.
- R12: `par_out` is the XOR of all eight bits of the result byte, for every operation.
- R13: For every operation except MUL and DIV, `res_b` equals `b_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Strobe that starts an operation |
| op_sel | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| b_in | input | 8 | B register operand |
| cy_in | input | 1 | Incoming carry |
| ac_in | input | 1 | Incoming auxiliary carry |
| ov_in | input | 1 | Incoming overflow |
| res_valid | output | 1 | High for one cycle after a strobe |
| res_a | output | 8 | Result for the accumulator |
| res_b | output | 8 | Result for the B register |
| cy_out | output | 1 | Carry flag |
| ac_out | output | 1 | Auxiliary carry flag |
| ov_out | output | 1 | Overflow flag |
| par_out | output | 1 | Parity of `res_a` |

## Verification
Two things can happen in a single cycle and are tested together. A single addition can raise carry, auxiliary carry and overflow at once; 0x88 plus 0x88 does this, and all three flags are judged against hand-worked values. Decimal adjust can apply both its low-nibble and high-nibble corrections in one operation; 0x9B does this, and the bench expects 0x01 with carry set. A second case expects the high correction to be driven only by an incoming carry. On top of the vector table, a random run checks every operation code against an arithmetic model written with integer operations.

// File: rtl/acu_pkg.sv
// Package: shared operation codes and result record for the accumulator ALU.
// Assumes an 8-bit datapath; the nibble width is derived from it.
package acu_pkg;
    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUBB = 5'd2,  OP_INC  = 5'd3,
        OP_DEC  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
        OP_RL   = 5'd8,  OP_RLC  = 5'd9,  OP_RR   = 5'd10, OP_RRC  = 5'd11,
        OP_SWAP = 5'd12, OP_DA   = 5'd13, OP_CMP  = 5'd14, OP_MUL  = 5'd15,
        OP_DIV  = 5'd16
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic          cy;
        logic          ac;
        logic          ov;
    } alu_res_t;
endpackage

// File: rtl/acu_addsub.sv
// Module: nibble-split adder and subtractor with carry/borrow, half-carry and
// signed overflow. Subtraction adds the inverted operand with inverted borrow
// and inverts the carries back into borrows. Purely combinational.
module acu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         hcout,
    output logic         ovf
);
    localparam int H = W / 2;

    logic [W-1:0] b_eff;
    logic         c0;
    logic [H:0]   lo;
    logic [W-H:0] hi;

    // Form the effective operand, then both nibble sums chained by carry.
    always_comb begin
        b_eff = sub ? ~b : b;
        c0    = sub ? ~cin : cin;
        lo    = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, c0};
        hi    = {1'b0, a[W-1:H]} + {1'b0, b_eff[W-1:H]} + {{(W-H){1'b0}}, lo[H]};
        sum   = {hi[W-H-1:0], lo[H-1:0]};
        cout  = hi[W-H] ^ sub;
        hcout = lo[H] ^ sub;
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/acu_decadj.sv
// Module: two-step BCD correction of the accumulator after an addition.
// Assumes the incoming carry and half-carry come from that addition.
// Combinational; the carry can only be set, never cleared.
module acu_decadj (
    input  logic [7:0] a,
    input  logic       cy,
    input  logic       ac,
    output logic [7:0] r,
    output logic       cy_o
);
    logic [8:0] s1;
    logic [8:0] s2;
    logic       c1;

    // Low-nibble fix first, then high-nibble fix using the updated carry.
    always_comb begin
        s1   = (a[3:0] > 4'd9 || ac) ? {1'b0, a} + 9'h006 : {1'b0, a};
        c1   = cy | s1[8];
        s2   = (s1[7:4] > 4'd9 || c1) ? {1'b0, s1[7:0]} + 9'h060 : {1'b0, s1[7:0]};
        r    = s2[7:0];
        cy_o = c1 | s2[8];
    end
endmodule

// File: rtl/acu_muldiv.sv
// Module: unsigned W x W multiply and W / W restoring divide.
// The divider is unrolled as W generate stages of compare-and-subtract.
// A zero divisor returns the operands unchanged and flags it.
module acu_muldiv #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] mul_lo,
    output logic [W-1:0] mul_hi,
    output logic         mul_big,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         div_zero
);
    logic [2*W-1:0] prod;
    logic [W:0]     part [W+1];
    logic [W-1:0]   qbit;

    // Full-width product and its high-byte test.
    always_comb begin
        prod    = a * b;
        mul_lo  = prod[W-1:0];
        mul_hi  = prod[2*W-1:W];
        mul_big = |prod[2*W-1:W];
    end

    assign part[0] = '0;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_div
            logic [W:0] shifted;
            // One restoring step: shift in the next dividend bit, try to subtract.
            always_comb begin
                shifted      = {part[i][W-1:0], a[W-1-i]};
                qbit[W-1-i]  = (shifted >= {1'b0, b});
                part[i+1]    = qbit[W-1-i] ? shifted - {1'b0, b} : shifted;
            end
        end
    endgenerate

    // A zero divisor keeps A and B as they were.
    always_comb begin
        div_zero = (b == '0);
        quo      = div_zero ? a : qbit;
        rem      = div_zero ? b : part[W][W-1:0];
    end
endmodule

// File: rtl/acc_alu8.sv
// Module: top of the accumulator ALU. Selects one operation per strobe and
// registers result, B byte and flags. Flags an operation does not define pass
// through from the inputs. Synchronous active-low reset clears all outputs.
module acc_alu8
    import acu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [OPW-1:0] op_sel,
    input  logic [DW-1:0]  acc_in,
    input  logic [DW-1:0]  opnd_in,
    input  logic [DW-1:0]  b_in,
    input  logic           cy_in,
    input  logic           ac_in,
    input  logic           ov_in,
    output logic           res_valid,
    output logic [DW-1:0]  res_a,
    output logic [DW-1:0]  res_b,
    output logic           cy_out,
    output logic           ac_out,
    output logic           ov_out,
    output logic           par_out
);
    logic [DW-1:0] as_sum, da_r, m_lo, m_hi, d_q, d_r;
    logic          as_c, as_h, as_v, as_sub, as_cin, da_c, m_big, d_zero;
    alu_res_t      nxt;

    // Carry-in and direction for the shared adder.
    always_comb begin
        as_sub = (op_sel == OP_SUBB) || (op_sel == OP_CMP);
        as_cin = (op_sel == OP_ADDC) || (op_sel == OP_SUBB) ? cy_in : 1'b0;
    end

    acu_addsub #(.W(DW)) u_as (
        .a(acc_in), .b(opnd_in), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .cout(as_c), .hcout(as_h), .ovf(as_v)
    );

    acu_decadj u_da (
        .a(acc_in), .cy(cy_in), .ac(ac_in), .r(da_r), .cy_o(da_c)
    );

    acu_muldiv #(.W(DW)) u_md (
        .a(acc_in), .b(b_in), .mul_lo(m_lo), .mul_hi(m_hi), .mul_big(m_big),
        .quo(d_q), .rem(d_r), .div_zero(d_zero)
    );

    // Pick the result record for the selected operation.
    always_comb begin
        nxt = '{a: acc_in, b: b_in, cy: cy_in, ac: ac_in, ov: ov_in};
        case (op_sel)
            OP_ADD, OP_ADDC, OP_SUBB: begin
                nxt.a = as_sum; nxt.cy = as_c; nxt.ac = as_h; nxt.ov = as_v;
            end
            OP_INC:  nxt.a = acc_in + 8'd1;
            OP_DEC:  nxt.a = acc_in - 8'd1;
            OP_AND:  nxt.a = acc_in & opnd_in;
            OP_OR:   nxt.a = acc_in | opnd_in;
            OP_XOR:  nxt.a = acc_in ^ opnd_in;
            OP_RL:   nxt.a = {acc_in[DW-2:0], acc_in[DW-1]};
            OP_RR:   nxt.a = {acc_in[0], acc_in[DW-1:1]};
            OP_RLC:  {nxt.cy, nxt.a} = {acc_in, cy_in};
            OP_RRC:  {nxt.a, nxt.cy} = {cy_in, acc_in};
            OP_SWAP: nxt.a = {acc_in[NW-1:0], acc_in[DW-1:NW]};
            OP_DA: begin
                nxt.a = da_r; nxt.cy = da_c;
            end
            OP_CMP:  nxt.cy = as_c;
            OP_MUL: begin
                nxt.a = m_lo; nxt.b = m_hi; nxt.cy = 1'b0; nxt.ov = m_big;
            end
            OP_DIV: begin
                nxt.a = d_q; nxt.b = d_r; nxt.cy = 1'b0; nxt.ov = d_zero;
            end
            default: ;
        endcase
    end

    // Output register: cleared on reset, loaded only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_a     <= '0;
            res_b     <= '0;
            cy_out    <= 1'b0;
            ac_out    <= 1'b0;
            ov_out    <= 1'b0;
            par_out   <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_a   <= nxt.a;
                res_b   <= nxt.b;
                cy_out  <= nxt.cy;
                ac_out  <= nxt.ac;
                ov_out  <= nxt.ov;
                par_out <= ^nxt.a;
            end
        end
    end

    // R1
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(res_a) && $stable(res_b) && $stable(cy_out));
    // R9
    mul_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_sel == OP_MUL |=>
            !cy_out && ({res_b, res_a} == $past(acc_in) * $past(b_in))
            && (ov_out == ($past(acc_in) * $past(b_in) > 16'd255)));
    // R11
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_sel == OP_DIV && b_in == '0 |=>
            ov_out && !cy_out && res_a == $past(acc_in) && res_b == '0);
    // R8
    cmp_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_sel == OP_CMP |=>
            res_a == $past(acc_in) && cy_out == ($past(acc_in) < $past(opnd_in)));
    // R5
    plain_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_sel == OP_RL || op_sel == OP_RR) |=> cy_out == $past(cy_in));
    // R6
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_sel == OP_SWAP |=>
            res_a == {$past(acc_in[NW-1:0]), $past(acc_in[DW-1:NW])});
    // R12
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> par_out == ^res_a);
endmodule

// File: tb/sim_acc_alu8.sv
module sim_acc_alu8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] acc_in = '0, opnd_in = '0, b_in = '0;
    logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
    logic       res_valid, cy_out, ac_out, ov_out, par_out;
    logic [7:0] res_a, res_b;
    int         n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    acc_alu8 u0 (
        .clk, .rst_n, .op_valid, .op_sel, .acc_in, .opnd_in, .b_in,
        .cy_in, .ac_in, .ov_in, .res_valid, .res_a, .res_b,
        .cy_out, .ac_out, .ov_out, .par_out
    );

    typedef struct packed {
        logic [4:0] op;
        logic [7:0] a, o, b;
        logic       ci, aci, ovi;
        logic [7:0] ea, eb;
        logic       ecy, eac, eov;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{5'd0,  8'h88, 8'h88, 8'h00, 1'b0, 1'b0, 1'b0, 8'h10, 8'h00, 1'b1, 1'b1, 1'b1},
        '{5'd1,  8'h7F, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h80, 8'h00, 1'b0, 1'b1, 1'b1},
        '{5'd2,  8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0},
        '{5'd2,  8'h80, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 8'h7F, 8'h00, 1'b0, 1'b1, 1'b1},
        '{5'd2,  8'h50, 8'h20, 8'h00, 1'b1, 1'b1, 1'b1, 8'h2F, 8'h00, 1'b0, 1'b1, 1'b0},
        '{5'd3,  8'hFF, 8'h00, 8'h33, 1'b1, 1'b1, 1'b1, 8'h00, 8'h33, 1'b1, 1'b1, 1'b1},
        '{5'd4,  8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0},
        '{5'd5,  8'hF0, 8'h3C, 8'h00, 1'b1, 1'b0, 1'b1, 8'h30, 8'h00, 1'b1, 1'b0, 1'b1},
        '{5'd6,  8'hF0, 8'h0F, 8'h00, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0},
        '{5'd7,  8'hFF, 8'h0F, 8'h00, 1'b0, 1'b0, 1'b0, 8'hF0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{5'd8,  8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h03, 8'h00, 1'b0, 1'b0, 1'b0},
        '{5'd9,  8'h81, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h02, 8'h00, 1'b1, 1'b0, 1'b0},
        '{5'd10, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h80, 8'h00, 1'b0, 1'b0, 1'b0},
        '{5'd11, 8'h02, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h81, 8'h00, 1'b0, 1'b0, 1'b0},
        '{5'd12, 8'hA5, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h5A, 8'h00, 1'b0, 1'b0, 1'b0},
        '{5'd13, 8'h9B, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'h00, 1'b1, 1'b0, 1'b0},
        '{5'd13, 8'h45, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'hA5, 8'h00, 1'b1, 1'b0, 1'b0},
        '{5'd13, 8'h12, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 8'h18, 8'h00, 1'b0, 1'b1, 1'b0},
        '{5'd14, 8'h10, 8'h20, 8'h00, 1'b0, 1'b0, 1'b0, 8'h10, 8'h00, 1'b1, 1'b0, 1'b0},
        '{5'd14, 8'h20, 8'h20, 8'h00, 1'b1, 1'b0, 1'b0, 8'h20, 8'h00, 1'b0, 1'b0, 1'b0},
        '{5'd15, 8'h10, 8'h00, 8'h10, 1'b0, 1'b1, 1'b0, 8'h00, 8'h01, 1'b0, 1'b1, 1'b1},
        '{5'd15, 8'h0F, 8'h00, 8'h11, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0},
        '{5'd16, 8'hFB, 8'h00, 8'h12, 1'b1, 1'b0, 1'b1, 8'h0D, 8'h11, 1'b0, 1'b0, 1'b0},
        '{5'd16, 8'h5A, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 8'h5A, 8'h00, 1'b0, 1'b1, 1'b1},
        '{5'd20, 8'h77, 8'h00, 8'h44, 1'b1, 1'b0, 1'b1, 8'h77, 8'h44, 1'b1, 1'b0, 1'b1}
    };

    // Requirement tag for an operation code.
    function automatic string tag_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1: return "R2";
            5'd2:       return "R3";
            5'd8, 5'd9, 5'd10, 5'd11: return "R5";
            5'd12:      return "R6";
            5'd13:      return "R7";
            5'd14:      return "R8";
            5'd15:      return "R9";
            5'd16:      return "R10/R11";
            default:    return "R4";
        endcase
    endfunction

    // Integer reference model: returns {a, b, cy, ac, ov}.
    function automatic logic [18:0] model(input logic [4:0] op, input logic [7:0] a,
        input logic [7:0] o, input logic [7:0] b, input logic ci, input logic aci,
        input logic ovi);
        int ra = a, rb = b, t, sa, so, sr;
        logic cy = ci, ac = aci, ov = ovi;
        sa = (a > 127) ? int'(a) - 256 : int'(a);
        so = (o > 127) ? int'(o) - 256 : int'(o);
        case (op)
            5'd0, 5'd1: begin
                t = (op == 5'd1) ? int'(ci) : 0;
                ra = (a + o + t) % 256; cy = (a + o + t) > 255;
                ac = (a % 16 + o % 16 + t) > 15;
                sr = sa + so + t; ov = (sr > 127) || (sr < -128);
            end
            5'd2: begin
                t = int'(ci);
                cy = (int'(a) - int'(o) - t) < 0; ra = (int'(a) - int'(o) - t + 512) % 256;
                ac = (int'(a % 16) - int'(o % 16) - t) < 0;
                sr = sa - so - t; ov = (sr > 127) || (sr < -128);
            end
            5'd3: ra = (a + 1) % 256;
            5'd4: ra = (a + 255) % 256;
            5'd5: ra = a & o;
            5'd6: ra = a | o;
            5'd7: ra = a ^ o;
            5'd8: ra = (a * 2) % 256 + a / 128;
            5'd9: begin ra = (a * 2) % 256 + int'(ci); cy = a[7]; end
            5'd10: ra = a / 2 + (a % 2) * 128;
            5'd11: begin ra = a / 2 + int'(ci) * 128; cy = a[0]; end
            5'd12: ra = (a % 16) * 16 + a / 16;
            5'd13: begin
                t = a;
                if (a % 16 > 9 || aci) t = t + 6;
                if (t > 255) cy = 1'b1;
                t = t % 256;
                if (t / 16 > 9 || cy) t = t + 96;
                if (t > 255) cy = 1'b1;
                ra = t % 256;
            end
            5'd14: cy = a < o;
            5'd15: begin t = a * b; ra = t % 256; rb = t / 256; cy = 1'b0; ov = t > 255; end
            5'd16: begin
                cy = 1'b0;
                if (b == 0) ov = 1'b1;
                else begin ra = a / b; rb = a % b; ov = 1'b0; end
            end
            default: ;
        endcase
        return {ra[7:0], rb[7:0], cy, ac, ov};
    endfunction

    // Issue one strobed operation and compare the registered outputs.
    task automatic run_op(input logic [4:0] op, input logic [7:0] a, input logic [7:0] o,
        input logic [7:0] b, input logic ci, input logic aci, input logic ovi,
        input logic [18:0] exp);
        logic [18:0] got;
        @(negedge clk);
        op_sel = op; acc_in = a; opnd_in = o; b_in = b;
        cy_in = ci; ac_in = aci; ov_in = ovi; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        got = {res_a, res_b, cy_out, ac_out, ov_out};
        n_run++;
        if (got !== exp || par_out !== ^exp[18:11] || res_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL %s/R1/R12/R13 op=%0d a=%h o=%h b=%h: got %h par %b vld %b, expected %h par %b",
                     tag_of(op), op, a, o, b, got, par_out, res_valid, exp, ^exp[18:11]);
        end
    endtask

    task automatic check1(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check1("R1", {res_valid, res_a, res_b, cy_out, ac_out, ov_out, par_out}, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i].op, VEC[i].a, VEC[i].o, VEC[i].b, VEC[i].ci, VEC[i].aci,
                   VEC[i].ovi, {VEC[i].ea, VEC[i].eb, VEC[i].ecy, VEC[i].eac, VEC[i].eov});
        end

        // R1 hold: change inputs without a strobe, outputs keep the last result
        run_op(5'd15, 8'h10, 8'h00, 8'h10, 1'b0, 1'b1, 1'b0, 19'({8'h00, 8'h01, 3'b011}));
        @(negedge clk);
        acc_in = 8'hFF; b_in = 8'hFF; op_sel = 5'd0; cy_in = 1'b1;
        repeat (3) @(negedge clk);
        check1("R1 hold", {res_valid, res_a, res_b, cy_out, ac_out, ov_out},
               {1'b0, 8'h00, 8'h01, 3'b011});

        // Random operands against the model for every code
        for (int k = 0; k < 600; k++) begin
            logic [4:0] op = 5'(k % 21);
            logic [7:0] a = 8'($urandom), o = 8'($urandom), b = 8'($urandom);
            logic [2:0] f = 3'($urandom);
            if (k % 37 == 0) b = 8'h00;
            run_op(op, a, o, b, f[0], f[1], f[2], model(op, a, o, b, f[0], f[1], f[2]));
        end

        // R1 synchronous reset clears results
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check1("R1 reset", {res_valid, res_a, res_b, cy_out, ac_out, ov_out, par_out}, '0);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule